// File: doc/BRIEF.md
# Byte/Word One-Time-Programmable ROM Read Port

This block is a synthesizable model of the read side of a one-time-programmable read-only memory. It holds a word array that a host can read as 16-bit words or, in byte mode, as twice as many 8-bit bytes. An extra low-order address bit picks which half of the addressed word appears on the low eight lanes. Every output lane has its own enable, so a bench or a board-level model can tell a driven lane from a floating one. The data lanes and their enables are registered one clock after the inputs are sampled. This register stands in for the access delay.

Two active-low controls gate the outputs. Chip enable selects the device, and output enable places data on the lanes. An identify flag replaces the high-voltage level on address bit 9. While it is set, the port returns fixed identifier words instead of array contents: a maker word when address bit 0 is low and a device word when it is high. Each identifier word has an odd number of ones, and its top bit is the parity bit. A narrow programming port lets a test write words into the array. Programming ANDs the new pattern into the cell, so it can clear bits but never set them.

Top module: `otp_rom_port`

## Requirements
- R1: During synchronous reset and on the first edge after it, all lane enables and all data lanes are 0. Every array word reads as 16'hFFFF until it is programmed.
- R2: If chip enable (active low) was high at an edge, all sixteen lane enables and data lanes are 0 after that edge, whatever output enable was.
- R3: If chip enable was low and output enable was high at an edge, all lane enables and data lanes are 0 after that edge.
- R4: In word mode with both enables low, one edge later all sixteen lane enables are 1. Data lane i then carries bit i of the word at array index addr[ARRAY_AW-1:0].
- R5: In byte mode with both enables low, lane enables equal 16'h00FF and lanes 8..15 carry 0. Lanes 0..7 carry word bits 15..8 when the extra address bit is 1, and word bits 7..0 when it is 0.
- R6: In identify mode with address bit 0 low the source word is 16'h00C2. With address bit 0 high it is 16'h0112, or the odd-parity form of 15'h0115 for the word-only variant. Address bit 9 is ignored. Byte mode steers the identifier word the same way it steers array data.
- R7: In identify mode, any address bit other than bits 0 and 9 being 1 makes the source word 16'hFFFF.
- R8: Every identifier word has an odd count of ones, with bit 15 serving as the parity bit.
- R9: A program strobe stores old & prog_data into the addressed cell. Bits that are 0 stay 0.
- R10: A read and a program of the same index in the same cycle returns the word held before the program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; fills the array with ones |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| byte_mode | input | 1 | 1 = byte-wide read, 0 = word-wide read |
| addr | input | 16 | Word address; bit 0 and the upper bits also drive identify decoding |
| addr_lsb | input | 1 | Byte select in byte mode (1 = upper half) |
| id_mode | input | 1 | Identify request, stands in for the high level on address bit 9 |
| prog_en | input | 1 | Program strobe for one word |
| prog_addr | input | ARRAY_AW | Array index to program |
| prog_data | input | 16 | Pattern ANDed into the cell |
| data_out | output | 16 | Registered data lanes |
| data_oe | output | 16 | Registered per-lane drive enables |

## Verification
The clocked properties assume that all control and address inputs are stable and defined at each rising edge. They also assume that the byte-lane and identify checks apply only while the variant allows byte mode. The stimulus changes every input on the falling edge only, so each rising edge sees settled values. Identify requests mostly use addresses whose only set bits are 0 and 9. A minority set exactly one other bit to exercise the rejection path. Program strobes cover the full index range, so that reads of the same index in the same cycle and repeat programs of one cell both occur.

// File: rtl/otp_rom_pkg.sv
package otp_rom_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ADDR_W = 16;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // identifier payloads without the parity bit
    localparam logic [WORD_W-2:0] MAKER_BASE     = 15'h00C2;
    localparam logic [WORD_W-2:0] DEV_BASE_DUAL  = 15'h0112;
    localparam logic [WORD_W-2:0] DEV_BASE_WIDE  = 15'h0115;

    // address bits that identify decoding does not require to be zero
    localparam addr_t ID_FREE_MASK = 16'h0201;

    typedef enum logic [1:0] {
        LANE_OFF,
        LANE_WORD,
        LANE_BYTE_LO,
        LANE_BYTE_HI
    } lane_mode_e;

    typedef struct packed {
        word_t data;
        word_t lane_en;
    } lane_out_t;

    // top bit makes the total count of ones odd
    function automatic word_t odd_parity_word(input logic [WORD_W-2:0] base);
        return {~(^base), base};
    endfunction

    function automatic logic id_addr_clean(input addr_t a);
        return (a & ~ID_FREE_MASK) == '0;
    endfunction

endpackage

// File: rtl/otp_cell_array.sv
module otp_cell_array
    import otp_rom_pkg::*;
#(
    parameter int unsigned ARRAY_AW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                prog_en,
    input  logic [ARRAY_AW-1:0] prog_idx,
    input  word_t               prog_data,
    input  logic [ARRAY_AW-1:0] rd_idx,
    output word_t               rd_word
);

    localparam int unsigned DEPTH = 1 << ARRAY_AW;

    word_t mem [DEPTH];
    word_t cell_at_prog;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (prog_en) begin
            mem[prog_idx] <= mem[prog_idx] & prog_data;
        end
    end

    assign rd_word      = mem[rd_idx];
    assign cell_at_prog = mem[prog_idx];

    // R9: a cell never gains a one through programming
    p_clear_only_r9: assert property (@(posedge clk) disable iff (rst)
        $past(prog_en && !rst) |-> ((mem[$past(prog_idx)] & ~$past(cell_at_prog)) == '0))
        else $error("p_clear_only_r9");

endmodule

// File: rtl/otp_id_gen.sv
module otp_id_gen
    import otp_rom_pkg::*;
#(
    parameter bit WORD_ONLY = 1'b0
) (
    input  addr_t addr,
    output word_t id_word
);

    localparam word_t MAKER_WORD = odd_parity_word(MAKER_BASE);
    localparam word_t DEV_WORD   = odd_parity_word(WORD_ONLY ? DEV_BASE_WIDE : DEV_BASE_DUAL);

    logic clean;

    always_comb begin
        clean = id_addr_clean(addr);
        if (!clean) begin
            id_word = '1;
        end else if (addr[0]) begin
            id_word = DEV_WORD;
        end else begin
            id_word = MAKER_WORD;
        end
    end

endmodule

// File: rtl/otp_lane_steer.sv
module otp_lane_steer
    import otp_rom_pkg::*;
(
    input  logic  enabled,
    input  logic  byte_sel,
    input  logic  hi_half,
    input  word_t src_word,
    output word_t lane_data,
    output word_t lane_en
);

    lane_mode_e mode;

    always_comb begin
        if (!enabled)      mode = LANE_OFF;
        else if (!byte_sel) mode = LANE_WORD;
        else if (hi_half)  mode = LANE_BYTE_HI;
        else               mode = LANE_BYTE_LO;
    end

    for (genvar g = 0; g < WORD_W; g++) begin : g_lane
        if (g < BYTE_W) begin : g_low
            always_comb begin
                unique case (mode)
                    LANE_WORD:    begin lane_en[g] = 1'b1; lane_data[g] = src_word[g];          end
                    LANE_BYTE_LO: begin lane_en[g] = 1'b1; lane_data[g] = src_word[g];          end
                    LANE_BYTE_HI: begin lane_en[g] = 1'b1; lane_data[g] = src_word[g + BYTE_W]; end
                    default:      begin lane_en[g] = 1'b0; lane_data[g] = 1'b0;                 end
                endcase
            end
        end else begin : g_high
            always_comb begin
                if (mode == LANE_WORD) begin
                    lane_en[g]   = 1'b1;
                    lane_data[g] = src_word[g];
                end else begin
                    lane_en[g]   = 1'b0;
                    lane_data[g] = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/otp_rom_port.sv
module otp_rom_port
    import otp_rom_pkg::*;
#(
    parameter int unsigned ARRAY_AW  = 8,
    parameter bit          WORD_ONLY = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ce_n,
    input  logic                oe_n,
    input  logic                byte_mode,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                addr_lsb,
    input  logic                id_mode,
    input  logic                prog_en,
    input  logic [ARRAY_AW-1:0] prog_addr,
    input  logic [WORD_W-1:0]   prog_data,
    output logic [WORD_W-1:0]   data_out,
    output logic [WORD_W-1:0]   data_oe
);

    word_t     rd_word;
    word_t     id_word;
    word_t     src_word;
    word_t     steer_data;
    word_t     steer_en;
    logic      enabled;
    logic      byte_sel;
    lane_out_t out_q;

    otp_cell_array #(.ARRAY_AW(ARRAY_AW)) u_array (
        .clk       (clk),
        .rst       (rst),
        .prog_en   (prog_en),
        .prog_idx  (prog_addr),
        .prog_data (prog_data),
        .rd_idx    (addr[ARRAY_AW-1:0]),
        .rd_word   (rd_word)
    );

    otp_id_gen #(.WORD_ONLY(WORD_ONLY)) u_id (
        .addr    (addr),
        .id_word (id_word)
    );

    assign enabled  = !ce_n && !oe_n;
    assign byte_sel = (WORD_ONLY == 1'b0) ? byte_mode : 1'b0;
    assign src_word = id_mode ? id_word : rd_word;

    otp_lane_steer u_steer (
        .enabled   (enabled),
        .byte_sel  (byte_sel),
        .hi_half   (addr_lsb),
        .src_word  (src_word),
        .lane_data (steer_data),
        .lane_en   (steer_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= '{data: steer_data, lane_en: steer_en};
        end
    end

    assign data_out = out_q.data;
    assign data_oe  = out_q.lane_en;

    // R2: deselected device floats every lane
    p_standby_float_r2: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && ce_n) |-> (data_oe == '0 && data_out == '0))
        else $error("p_standby_float_r2");

    // R3: output enable high floats every lane
    p_output_gate_r3: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !ce_n && oe_n) |-> (data_oe == '0 && data_out == '0))
        else $error("p_output_gate_r3");

    // R5: byte reads drive only the low lanes
    p_byte_lanes_r5: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !WORD_ONLY && !ce_n && !oe_n && byte_mode)
        |-> (data_oe == 16'h00FF && data_out[WORD_W-1:BYTE_W] == '0))
        else $error("p_byte_lanes_r5");

    // R8: a clean identify word read shows odd parity
    p_id_parity_r8: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !ce_n && !oe_n && !byte_sel && id_mode && id_addr_clean(addr))
        |-> (^data_out))
        else $error("p_id_parity_r8");

    // R7: identify with a stray address bit returns all ones
    p_id_reject_r7: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !ce_n && !oe_n && !byte_sel && id_mode && !id_addr_clean(addr))
        |-> (data_out == '1))
        else $error("p_id_reject_r7");

endmodule

// File: tb/otp_rom_port_tb.sv
`timescale 1ns/1ps
module otp_rom_port_tb_top;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          byte_mode = 1'b0;
    logic [15:0]   addr = '0;
    logic          addr_lsb = 1'b0;
    logic          id_mode = 1'b0;
    logic          prog_en = 1'b0;
    logic [AW-1:0] prog_addr = '0;
    logic [15:0]   prog_data = '0;
    logic [15:0]   data_out;
    logic [15:0]   data_oe;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;
    logic [15:0] shadow [1 << AW];

    always #4 clk = ~clk;

    otp_rom_port #(.ARRAY_AW(AW), .WORD_ONLY(1'b0)) dut_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .byte_mode(byte_mode),
        .addr(addr), .addr_lsb(addr_lsb), .id_mode(id_mode), .prog_en(prog_en),
        .prog_addr(prog_addr), .prog_data(prog_data),
        .data_out(data_out), .data_oe(data_oe)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got oe/data %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_id(input logic [15:0] a);
        if ((a & 16'hFDFE) != 16'h0000) return 16'hFFFF;
        return a[0] ? 16'h0112 : 16'h00C2;
    endfunction

    function automatic logic [31:0] exp_out();
        logic [15:0] w;
        if (ce_n || oe_n) return 32'h0;
        w = id_mode ? exp_id(addr) : shadow[addr[AW-1:0]];
        if (byte_mode) return {16'h00FF, 8'h00, (addr_lsb ? w[15:8] : w[7:0])};
        return {16'hFFFF, w};
    endfunction

    function automatic string pick_tag();
        if (ce_n) return "R2";
        if (oe_n) return "R3";
        if (id_mode && (addr & 16'hFDFE) != 0) return "R7";
        if (id_mode) return "R6";
        if (byte_mode) return "R5";
        return "R4";
    endfunction

    task automatic set_in(input logic c, input logic o, input logic b, input logic [15:0] a,
                          input logic l, input logic i);
        ce_n = c; oe_n = o; byte_mode = b; addr = a; addr_lsb = l; id_mode = i;
    endtask

    // one cycle: expected from pre-edge state, shadow updated at the edge
    task automatic step(input string tag);
        logic [31:0] e;
        e = exp_out();
        @(posedge clk);
        if (prog_en) shadow[prog_addr] = shadow[prog_addr] & prog_data;
        @(negedge clk);
        check(tag, {data_oe, data_out}, e);
        prog_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        for (int i = 0; i < (1 << AW); i++) shadow[i] = 16'hFFFF;
        set_in(1'b0, 1'b0, 1'b0, 16'h0005, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset outputs", {data_oe, data_out}, 32'h0);
        rst = 1'b0;
        step("R1 erased word");
        set_in(1'b0, 1'b0, 1'b1, 16'h00A0, 1'b1, 1'b0);
        step("R1 erased byte");

        // R9 directed: clear-only programming
        set_in(1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0);
        prog_en = 1'b1; prog_addr = 8'd3; prog_data = 16'hA5F0; step("R2 during program");
        prog_en = 1'b1; prog_addr = 8'd3; prog_data = 16'hFFFF; step("R2 during program");
        prog_en = 1'b1; prog_addr = 8'd3; prog_data = 16'h0FFF; step("R2 during program");
        set_in(1'b0, 1'b0, 1'b0, 16'h0003, 1'b0, 1'b0);
        check("R9 model", {16'h0, shadow[3]}, {16'h0, 16'h05F0});
        step("R9 word after clears");
        set_in(1'b0, 1'b0, 1'b1, 16'h0003, 1'b1, 1'b0); step("R5 upper byte");
        set_in(1'b0, 1'b0, 1'b1, 16'h0003, 1'b0, 1'b0); step("R5 lower byte");

        // R10: same-cycle read and program
        set_in(1'b0, 1'b0, 1'b0, 16'h0007, 1'b0, 1'b0);
        prog_en = 1'b1; prog_addr = 8'd7; prog_data = 16'h1234;
        step("R10 old value on collision");
        step("R10 new value after");

        // R2/R3 float
        set_in(1'b1, 1'b0, 1'b0, 16'h0003, 1'b0, 1'b0); step("R2 ce high oe low");
        set_in(1'b0, 1'b1, 1'b1, 16'h0003, 1'b0, 1'b0); step("R3 oe high");

        // identify
        set_in(1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1); step("R6 maker word");
        check("R8 maker parity", {31'h0, ^data_out}, 32'h1);
        set_in(1'b0, 1'b0, 1'b0, 16'h0001, 1'b0, 1'b1); step("R6 device word");
        check("R8 device parity", {31'h0, ^data_out}, 32'h1);
        set_in(1'b0, 1'b0, 1'b0, 16'h0201, 1'b0, 1'b1); step("R6 bit9 ignored");
        set_in(1'b0, 1'b0, 1'b1, 16'h0001, 1'b0, 1'b1); step("R6 device low byte");
        set_in(1'b0, 1'b0, 1'b1, 16'h0001, 1'b1, 1'b1); step("R6 device high byte");
        set_in(1'b0, 1'b0, 1'b0, 16'h0004, 1'b0, 1'b1); step("R7 stray bit");
        set_in(1'b0, 1'b0, 1'b1, 16'h8000, 1'b0, 1'b1); step("R7 stray bit byte");

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] a;
            logic        idm;
            idm = ($urandom_range(0, 4) == 0);
            if (idm) begin
                a = {6'b0, 1'($urandom_range(0, 1)), 8'b0, 1'($urandom_range(0, 1))};
                if ($urandom_range(0, 3) == 0) a = a | (16'h1 << $urandom_range(1, 15));
            end else begin
                a = 16'($urandom);
            end
            set_in(($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
                   1'($urandom_range(0, 1)), a, 1'($urandom_range(0, 1)), idm);
            if ($urandom_range(0, 3) == 0) begin
                prog_en   = 1'b1;
                prog_addr = AW'($urandom);
                prog_data = 16'($urandom) | 16'($urandom);
            end
            step(pick_tag());
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule